// File: doc/BRIEF.md
# Erase-Block Write Protection Controller

This controller sits beside a flash array and decides which erase blocks may be programmed or erased. It keeps a single unlocked window, given by a first and a last block number. Every block outside that window is protected. A sticky hardened mode freezes the protection settings, and only a sustained low level on the write-protect pin can release it. The controller sees the command and address cycles that the host interface has already latched. From these it decodes the window-setting, lock-all, harden and status-query sequences.

Before the array starts a program or erase, the sequencer presents the target block on a request port. One cycle later the controller returns allow or deny. A denied request raises a short dummy busy instead of touching the array. A separate query sequence returns a one-hot status byte for any block. When the feature-enable pin is low, every block counts as writable.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset, with the enable pin high, every block is protected: a status query returns 8'h02 and a program/erase request is denied.
- R2: While `lock_en` is low, every block is reported unlocked (status 8'h01) and every request is allowed, whatever the stored settings.
- R3: The sequence command 8'h23, address S, command 8'h24, address E (S <= E) makes blocks S through E inclusive unlocked. All other blocks stay protected.
- R4: A later complete window sequence replaces the earlier window entirely.
- R5: A window sequence with S > E leaves no block unlocked.
- R6: Command 8'h2A protects every block (the window is emptied).
- R7: Command 8'h2C, with the synchronized `wp_n` high, enters hardened mode. Blocks outside the window then report 8'h04 and blocks inside stay unlocked. With `wp_n` low, 8'h2C has no effect.
- R8: In hardened mode, the window sequence and 8'h2A are ignored.
- R9: Holding `wp_n` low for WP_LOW_CYC consecutive clock edges leaves hardened mode and protects every block. A shorter low pulse changes nothing.
- R10: A request on `pe_req` is answered on the next cycle by `pe_resp` with `pe_allow`. A deny holds `dummy_busy` high for exactly DUMMY_CYC cycles, starting on the response cycle. An allow raises no busy.
- R11: Command 8'h7A followed by an address cycle gives `sts_valid` on the next cycle, with `sts_byte` bit 2 = hardened, bit 1 = protected, bit 0 = unlocked. Exactly one of these bits is set and bits 7..3 are zero.
- R12: Any other command between 8'h23 and 8'h24 abandons the window sequence. An address cycle that no sequence expects is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lock_en | input | 1 | Feature enable; low makes every block writable |
| wp_n | input | 1 | Write-protect pin, asynchronous, active low |
| cmd_wr | input | 1 | A latched command byte is present this cycle |
| cmd_code | input | 8 | Command byte |
| addr_wr | input | 1 | A latched block address is present this cycle |
| addr_blk | input | BLK_W | Block number of the address cycle |
| pe_req | input | 1 | Program/erase permission request |
| pe_blk | input | BLK_W | Block targeted by the request |
| pe_resp | output | 1 | Response strobe, one cycle after `pe_req` |
| pe_allow | output | 1 | High if the requested block may be written |
| dummy_busy | output | 1 | Dummy busy after a denied request |
| sts_valid | output | 1 | Status byte strobe |
| sts_byte | output | 8 | One-hot protection status of the queried block |

## Verification
The hardest situation to reach is the hardened mode combined with the write-protect timing. Entering it needs `wp_n` high at the synchronizer output. Leaving it needs an exact count of consecutive low edges, and a pulse one edge short must leave it intact. The stimulus holds `wp_n` low only briefly around an 8'h2C command, so the command is seen while protect is active, yet the pulse stays too short to clear anything. It then drives low pulses of WP_LOW_CYC-1 and WP_LOW_CYC edges and probes the window edges through queries. Random window sequences with biased boundary probes cover the inclusive-range and empty-range cases.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  // One-hot status encoding, also used as the low bits of the status byte
  typedef enum logic [2:0] {
    ST_UNLOCKED = 3'b001,
    ST_LOCKED   = 3'b010,
    ST_TIGHT    = 3'b100
  } lk_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL_START,
    SQ_UNL_MID,
    SQ_UNL_END,
    SQ_QRY_ADDR
  } seq_e;

  localparam logic [7:0] CMD_WIN_FIRST = 8'h23;
  localparam logic [7:0] CMD_WIN_LAST  = 8'h24;
  localparam logic [7:0] CMD_LOCK_ALL  = 8'h2A;
  localparam logic [7:0] CMD_HARDEN    = 8'h2C;
  localparam logic [7:0] CMD_QUERY     = 8'h7A;
endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
  import blk_lock_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             addr_wr,
  input  logic [BLK_W-1:0] addr_blk,
  output logic             ev_window,
  output logic [BLK_W-1:0] win_lo,
  output logic [BLK_W-1:0] win_hi,
  output logic             ev_lock_all,
  output logic             ev_harden,
  output logic             ev_query,
  output logic [BLK_W-1:0] q_blk
);
  seq_e             seq_q, seq_d;
  logic [BLK_W-1:0] lo_q, lo_d;

  always_comb begin
    seq_d       = seq_q;
    lo_d        = lo_q;
    ev_window   = 1'b0;
    ev_lock_all = 1'b0;
    ev_harden   = 1'b0;
    ev_query    = 1'b0;
    if (cmd_wr) begin
      case (cmd_code)
        CMD_WIN_FIRST: seq_d = SQ_UNL_START;
        CMD_WIN_LAST:  seq_d = (seq_q == SQ_UNL_MID) ? SQ_UNL_END : SQ_IDLE;
        CMD_QUERY:     seq_d = SQ_QRY_ADDR;
        CMD_LOCK_ALL: begin
          ev_lock_all = 1'b1;
          seq_d       = SQ_IDLE;
        end
        CMD_HARDEN: begin
          ev_harden = 1'b1;
          seq_d     = SQ_IDLE;
        end
        default:       seq_d = SQ_IDLE;
      endcase
    end else if (addr_wr) begin
      case (seq_q)
        SQ_UNL_START: begin
          lo_d  = addr_blk;
          seq_d = SQ_UNL_MID;
        end
        SQ_UNL_END: begin
          ev_window = 1'b1;
          seq_d     = SQ_IDLE;
        end
        SQ_QRY_ADDR: begin
          ev_query = 1'b1;
          seq_d    = SQ_IDLE;
        end
        default: seq_d = seq_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      lo_q  <= '0;
    end else begin
      seq_q <= seq_d;
      lo_q  <= lo_d;
    end
  end

  assign win_lo = lo_q;
  assign win_hi = addr_blk;
  assign q_blk  = addr_blk;
endmodule

// File: rtl/blk_lock_wp_filt.sv
module blk_lock_wp_filt #(
  parameter int LOW_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic wp_hi,
  output logic wp_clr
);
  localparam int CNT_W = $clog2(LOW_CYC + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], wp_n};
  end

  assign wp_hi = sync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    if (wp_hi)                            cnt_d = '0;
    else if (cnt_q != CNT_W'(LOW_CYC))    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wp_clr = !wp_hi && (cnt_q == CNT_W'(LOW_CYC - 1));
endmodule

// File: rtl/blk_lock_regs.sv
module blk_lock_regs #(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_window,
  input  logic [BLK_W-1:0] win_lo,
  input  logic [BLK_W-1:0] win_hi,
  input  logic             ev_lock_all,
  input  logic             ev_harden,
  input  logic             wp_hi,
  input  logic             wp_clr,
  output logic             tight,
  output logic             rng_vld,
  output logic [BLK_W-1:0] rng_lo,
  output logic [BLK_W-1:0] rng_hi
);
  logic             tight_d, vld_d;
  logic [BLK_W-1:0] lo_d, hi_d;
  logic             upd_en;

  always_comb begin
    tight_d = tight;
    vld_d   = rng_vld;
    lo_d    = rng_lo;
    hi_d    = rng_hi;
    if (wp_clr) begin
      tight_d = 1'b0;
      vld_d   = 1'b0;
    end else if (!tight) begin
      if (ev_window) begin
        lo_d  = win_lo;
        hi_d  = win_hi;
        vld_d = (win_lo <= win_hi);
      end else if (ev_lock_all) begin
        vld_d = 1'b0;
      end else if (ev_harden && wp_hi) begin
        tight_d = 1'b1;
      end
    end
  end

  assign upd_en = wp_clr || ev_window || ev_lock_all || ev_harden;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tight   <= 1'b0;
      rng_vld <= 1'b0;
      rng_lo  <= '0;
      rng_hi  <= '0;
    end else if (upd_en) begin
      tight   <= tight_d;
      rng_vld <= vld_d;
      rng_lo  <= lo_d;
      rng_hi  <= hi_d;
    end
  end
endmodule

// File: rtl/blk_lock_class.sv
module blk_lock_class
  import blk_lock_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic             en,
  input  logic             tight,
  input  logic             rng_vld,
  input  logic [BLK_W-1:0] rng_lo,
  input  logic [BLK_W-1:0] rng_hi,
  input  logic [BLK_W-1:0] blk,
  output lk_state_e        state
);
  logic in_win;

  assign in_win = rng_vld && (blk >= rng_lo) && (blk <= rng_hi);

  always_comb begin
    if (!en || in_win) state = ST_UNLOCKED;
    else if (tight)    state = ST_TIGHT;
    else               state = ST_LOCKED;
  end
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int  NUM_BLOCKS = 2048,
  parameter int  DUMMY_CYC  = 8,
  parameter int  WP_LOW_CYC = 6,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic             wp_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             addr_wr,
  input  logic [BLK_W-1:0] addr_blk,
  input  logic             pe_req,
  input  logic [BLK_W-1:0] pe_blk,
  output logic             pe_resp,
  output logic             pe_allow,
  output logic             dummy_busy,
  output logic             sts_valid,
  output logic [7:0]       sts_byte
);
  localparam int BUSY_W = $clog2(DUMMY_CYC + 1);
  localparam int N_LOOK = 2;

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic             ev_window, ev_lock_all, ev_harden, ev_query;
  logic [BLK_W-1:0] win_lo, win_hi, q_blk;
  logic             wp_hi, wp_clr;
  logic             tight, rng_vld;
  logic [BLK_W-1:0] rng_lo, rng_hi;

  blk_lock_seq #(.BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .addr_wr(addr_wr), .addr_blk(addr_blk),
    .ev_window(ev_window), .win_lo(win_lo), .win_hi(win_hi),
    .ev_lock_all(ev_lock_all), .ev_harden(ev_harden),
    .ev_query(ev_query), .q_blk(q_blk)
  );

  blk_lock_wp_filt #(.LOW_CYC(WP_LOW_CYC)) u_wp (
    .clk(clk), .rst_n(rst_sn), .wp_n(wp_n),
    .wp_hi(wp_hi), .wp_clr(wp_clr)
  );

  blk_lock_regs #(.BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .ev_window(ev_window), .win_lo(win_lo), .win_hi(win_hi),
    .ev_lock_all(ev_lock_all), .ev_harden(ev_harden),
    .wp_hi(wp_hi), .wp_clr(wp_clr),
    .tight(tight), .rng_vld(rng_vld), .rng_lo(rng_lo), .rng_hi(rng_hi)
  );

  // Lookup port 0 serves program/erase requests, port 1 serves status queries
  logic [BLK_W-1:0] look_blk [N_LOOK];
  lk_state_e        look_st  [N_LOOK];

  assign look_blk[0] = pe_blk;
  assign look_blk[1] = q_blk;

  for (genvar gi = 0; gi < N_LOOK; gi++) begin : g_look
    blk_lock_class #(.BLK_W(BLK_W)) u_cls (
      .en(lock_en), .tight(tight), .rng_vld(rng_vld),
      .rng_lo(rng_lo), .rng_hi(rng_hi),
      .blk(look_blk[gi]), .state(look_st[gi])
    );
  end

  // Program/erase response and dummy busy
  logic              pe_ok;
  logic              allow_q;
  logic              resp_q;
  logic [BUSY_W-1:0] busy_q, busy_d;

  assign pe_ok = (look_st[0] == ST_UNLOCKED);

  always_comb begin
    busy_d = busy_q;
    if (pe_req && !pe_ok) busy_d = BUSY_W'(DUMMY_CYC);
    else if (busy_q != '0) busy_d = busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      resp_q  <= 1'b0;
      allow_q <= 1'b0;
      busy_q  <= '0;
    end else begin
      resp_q <= pe_req;
      busy_q <= busy_d;
      if (pe_req) allow_q <= pe_ok;
    end
  end

  assign pe_resp    = resp_q;
  assign pe_allow   = allow_q;
  assign dummy_busy = (busy_q != '0);

  // Status query result
  logic      sv_q;
  lk_state_e sst_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sv_q  <= 1'b0;
      sst_q <= ST_LOCKED;
    end else begin
      sv_q <= ev_query;
      if (ev_query) sst_q <= look_st[1];
    end
  end

  assign sts_valid = sv_q;
  assign sts_byte  = {5'b00000, sst_q};
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
  parameter int  NUM_BLOCKS = 2048,
  parameter int  DUMMY_CYC  = 8,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_en,
  input logic       addr_wr,
  input logic       pe_req,
  input logic       pe_resp,
  input logic       pe_allow,
  input logic       dummy_busy,
  input logic       sts_valid,
  input logic [7:0] sts_byte
);
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |=> pe_resp); // R10
  AST_DENY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_resp && !pe_allow) |-> dummy_busy); // R10
  AST_STS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> ($countones(sts_byte[2:0]) == 1 && sts_byte[7:3] == 5'b0)); // R11
  AST_STS_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> $past(addr_wr)); // R11
  AST_EN_LOW_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && !lock_en) |=> pe_allow); // R2
  AST_EN_LOW_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !lock_en) |=> (!sts_valid || sts_byte == 8'h01)); // R2
endmodule

bind blk_lock_ctrl blk_lock_chk #(.NUM_BLOCKS(NUM_BLOCKS), .DUMMY_CYC(DUMMY_CYC)) chk_i (
  .clk(clk), .rst_n(rst_sn), .lock_en(lock_en), .addr_wr(addr_wr),
  .pe_req(pe_req), .pe_resp(pe_resp), .pe_allow(pe_allow),
  .dummy_busy(dummy_busy), .sts_valid(sts_valid), .sts_byte(sts_byte)
);

// File: tb/blk_lock_ctrl_tb_top.sv
module blk_lock_ctrl_tb_top;
  localparam int NB    = 2048;
  localparam int BW    = $clog2(NB);
  localparam int DUMMY = 8;
  localparam int WPLOW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lock_en = 1'b1;
  logic          wp_n = 1'b1;
  logic          cmd_wr = 1'b0;
  logic [7:0]    cmd_code = 8'h00;
  logic          addr_wr = 1'b0;
  logic [BW-1:0] addr_blk = '0;
  logic          pe_req = 1'b0;
  logic [BW-1:0] pe_blk = '0;
  logic          pe_resp, pe_allow, dummy_busy, sts_valid;
  logic [7:0]    sts_byte;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  blk_lock_ctrl #(.NUM_BLOCKS(NB), .DUMMY_CYC(DUMMY), .WP_LOW_CYC(WPLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .wp_n(wp_n),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .addr_wr(addr_wr), .addr_blk(addr_blk),
    .pe_req(pe_req), .pe_blk(pe_blk), .pe_resp(pe_resp), .pe_allow(pe_allow),
    .dummy_busy(dummy_busy), .sts_valid(sts_valid), .sts_byte(sts_byte)
  );

  // Reference model of the protection settings
  bit m_tight = 0;
  bit m_vld   = 0;
  int m_lo    = 0;
  int m_hi    = 0;

  function automatic logic [7:0] exp_sts(int b);
    if (!lock_en) return 8'h01;
    if (m_vld && b >= m_lo && b <= m_hi) return 8'h01;
    return m_tight ? 8'h04 : 8'h02;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_cmd(logic [7:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic put_addr(int b);
    @(negedge clk); addr_wr = 1'b1; addr_blk = BW'(b);
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic do_window(int s, int e);
    put_cmd(8'h23); put_addr(s); put_cmd(8'h24); put_addr(e);
    if (!m_tight) begin m_lo = s; m_hi = e; m_vld = (s <= e); end
  endtask

  task automatic do_lock_all();
    put_cmd(8'h2A);
    if (!m_tight) m_vld = 0;
  endtask

  task automatic query(int b, string req);
    logic [7:0] e;
    put_cmd(8'h7A);
    @(negedge clk); addr_wr = 1'b1; addr_blk = BW'(b);
    e = exp_sts(b);
    @(negedge clk); addr_wr = 1'b0;
    check(sts_valid === 1'b1, req, int'(sts_valid), 1);
    check(sts_byte === e, req, int'(sts_byte), int'(e));
  endtask

  task automatic pe(int b, string req);
    bit ok;
    int n;
    ok = (exp_sts(b) == 8'h01);
    @(negedge clk); pe_req = 1'b1; pe_blk = BW'(b);
    @(negedge clk); pe_req = 1'b0;
    check(pe_resp === 1'b1 && pe_allow === ok, req, int'({pe_resp, pe_allow}), int'({1'b1, ok}));
    check(dummy_busy === !ok, req, int'(dummy_busy), int'(!ok));
    n = 0;
    while (dummy_busy && n < 100) begin n++; @(negedge clk); end
    if (!ok) check(n == DUMMY, req, n, DUMMY);
  endtask

  task automatic wp_pulse(int n);
    @(negedge clk); wp_n = 1'b0;
    repeat (n) @(negedge clk);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    if (n >= WPLOW) begin m_tight = 0; m_vld = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(pe_resp === 1'b0 && sts_valid === 1'b0 && dummy_busy === 1'b0, "R1", 0, 0);
    query(0, "R1"); query(NB-1, "R1"); pe(7, "R1");

    // R2 feature disabled
    lock_en = 1'b0;
    query(100, "R2"); pe(100, "R2");
    lock_en = 1'b1;

    // R3 inclusive window
    do_window(10, 20);
    query(9, "R3"); query(10, "R3"); query(20, "R3"); query(21, "R3");
    pe(15, "R3"); pe(21, "R10");

    // R4 replacement
    do_window(500, 500);
    query(15, "R4"); query(500, "R4"); query(501, "R4");

    // R5 reversed bounds
    do_window(40, 30);
    query(35, "R5"); query(40, "R5"); query(30, "R5");

    // R12 broken sequence and stray addresses
    do_window(100, 200);
    put_cmd(8'h23); put_addr(0); put_cmd(8'h80); put_cmd(8'h24); put_addr(NB-1);
    put_addr(3);
    query(0, "R12"); query(150, "R12"); query(NB-1, "R12");

    // R6 lock all
    do_lock_all();
    query(150, "R6"); pe(150, "R6");

    // R7 harden ignored while protect pin low (short low pulse)
    do_window(300, 310);
    @(negedge clk); wp_n = 1'b0;
    repeat (2) @(negedge clk);
    put_cmd(8'h2C);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);
    query(299, "R7");

    // R7 harden with pin high
    put_cmd(8'h2C); m_tight = 1;
    query(299, "R7"); query(305, "R7"); pe(299, "R7"); pe(310, "R7");

    // R8 commands ignored while hardened
    do_window(0, NB-1);
    query(0, "R8");
    do_lock_all();
    query(305, "R8");

    // R9 short pulse keeps hardened mode, full pulse clears it
    wp_pulse(WPLOW - 1);
    query(0, "R9"); query(305, "R9");
    wp_pulse(WPLOW);
    query(0, "R9"); query(305, "R9");
    do_window(1, 2);
    query(2, "R9");

    // Random windows with boundary probes (R3, R4, R5, R10, R11)
    for (int i = 0; i < 40; i++) begin
      int op, s, e, b;
      op = $urandom_range(0, 4);
      case (op)
        0, 1: begin
          s = $urandom_range(0, NB-1);
          e = (op == 0) ? $urandom_range(s, (s + 40 < NB) ? s + 40 : NB-1)
                        : $urandom_range(0, NB-1);
          do_window(s, e);
        end
        2: do_lock_all();
        default: begin
          case ($urandom_range(0, 3))
            0: b = m_lo;
            1: b = m_hi;
            2: b = (m_hi + 1) % NB;
            default: b = $urandom_range(0, NB-1);
          endcase
          if ($urandom_range(0, 1) == 0) query(b, "R11");
          else pe(b, "R10");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule